// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a parallel I/O port of up to 32 pins, reached through a small word-addressed register bus. Software sets a per-pin output value and a per-pin output enable. It reads back the levels on the pins, which are resynchronised into the local clock. Each input is also watched for transitions. Transitions of the kind chosen at build time are latched into a sticky capture register. Software clears that register by writing ones.

A single interrupt line goes to the host. The trigger kind is a build parameter and cannot be changed at run time. In the three edge kinds (rising, falling, either), the line is high while any captured bit is also enabled in the interrupt enable register. In the level kind, the line follows the enabled pin levels directly and nothing is captured.

Top module: `pio_edge_port`

## Requirements
- R1: After reset, the output latch, the direction register, the interrupt enable register and the capture register are all zero. All pins are inputs (`pin_oe` = 0) and `irq` is low.
- R2: A write to word 1 sets `pin_oe` (bit = 1 drives the pin). A write to word 0 sets `pin_out`. Both outputs stay unchanged unless their own word is written.
- R3: A read of word 0 returns the driven latch value on pins whose direction bit is 1, and the synchronised pin level on the other pins.
- R4: Bits at or above `PIN_COUNT` read as zero in every register, and writes to them are ignored.
- R5: Reads of word addresses 4 and above return zero. Writes to those addresses change no register.
- R6: In rising mode, a 0-to-1 change on an input sets its bit in word 3, even when that bit is masked. The bit stays set until it is cleared.
- R7: In falling mode, only 1-to-0 changes set capture bits. In either-edge mode, both directions set them.
- R8: Writing a 1 to a bit of word 3 clears that bit. Writing a 0 leaves the bit unchanged.
- R9: When an edge event and a clear of the same capture bit fall in the same clock cycle, the bit stays set.
- R10: In edge modes, `irq` is high exactly while some bit is set in both word 3 and word 2 (the interrupt enable register, 1 = enabled). Enabling a bit that already holds a pending capture raises `irq` at once. `irq` rises three clock edges after an input change: two synchroniser stages, then capture.
- R11: In level mode, `irq` is high while some enabled pin's synchronised level is 1, two edges after the pin change. It falls again when the pin falls, and word 3 reads zero.
- R12: Read data appears on `bus_rdata` after the rising edge that samples the read request, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (0 data, 1 direction, 2 enable, 3 capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch value |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear of a capture bit that lands in the same cycle as a new edge on that bit. The edge only becomes visible after two synchroniser stages, so the pin change has to lead the clear write by exactly two edges. The bench first sets the bit, then makes the pin go back to its starting level. It then changes the pin again and schedules the clearing write to be sampled on the third edge after that change. The same edge counting is used to check the cycle at which `irq` rises in both edge and level modes.

// File: rtl/pio_pkg.sv
// Package: shared types and register word addresses for the GPIO port.
// Assumes a word-addressed bus in which each register takes one word slot.
package pio_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam int unsigned WORD_DATA = 0;
    localparam int unsigned WORD_DIR  = 1;
    localparam int unsigned WORD_IEN  = 2;
    localparam int unsigned WORD_CAP  = 3;
    localparam int unsigned WORD_LAST = 3;
    localparam int unsigned BUS_W     = 32;
endpackage

// File: rtl/pio_in_stage.sv
// Module: input conditioning. It passes each pin through two flops and keeps
// one more delayed copy, then forms a one-cycle event pulse for the chosen
// trigger kind. Assumes pin_in is asynchronous to clk.
module pio_in_stage #(
    parameter int unsigned     W       = 32,
    parameter pio_pkg::trig_e TRIGGER = pio_pkg::TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] evt
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchroniser chain plus one delayed copy used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl = sync_q;

    // Event pulse selection per trigger kind.
    generate
        if (TRIGGER == pio_pkg::TRIG_RISE) begin : g_rise
            assign evt = sync_q & ~prev_q;
        end else if (TRIGGER == pio_pkg::TRIG_FALL) begin : g_fall
            assign evt = ~sync_q & prev_q;
        end else if (TRIGGER == pio_pkg::TRIG_BOTH) begin : g_both
            assign evt = sync_q ^ prev_q;
        end else begin : g_level
            logic [W-1:0] unused_prev;
            assign unused_prev = prev_q;
            assign evt = '0;
        end
    endgenerate
endmodule

// File: rtl/pio_capture.sv
// Module: sticky capture register. Event pulses set bits and a clear vector
// (write-one) resets them. A set and a clear in the same cycle leave the bit set.
module pio_capture #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cap_q
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr) | evt;
    end
endmodule

// File: rtl/pio_edge_port.sv
// Module: top of the GPIO port. It decodes the register bus, holds the output,
// direction and interrupt enable registers, registers read data, and forms the
// interrupt. Assumes PIN_COUNT is between 1 and 32, and that one access is
// presented per cycle, with bus_sel qualifying it.
module pio_edge_port #(
    parameter int unsigned     PIN_COUNT = 32,
    parameter int unsigned     ADDR_W    = 3,
    parameter pio_pkg::trig_e TRIGGER   = pio_pkg::TRIG_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam int unsigned W = PIN_COUNT;

    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] cap_q;
    logic [W-1:0] lvl;
    logic [W-1:0] evt;
    logic [W-1:0] wr_val;
    logic [W-1:0] data_view;
    logic [31:0]  rd_mux;
    logic [31:0]  rdata_q;
    logic         wr_en;
    logic         rd_en;
    logic         wr_data;
    logic         wr_dir;
    logic         wr_ien;
    logic         wr_cap;

    // Access qualification and per-register write strobes.
    assign wr_en   = bus_sel & bus_wr;
    assign rd_en   = bus_sel & ~bus_wr;
    assign wr_data = wr_en && (int'(bus_addr) == pio_pkg::WORD_DATA);
    assign wr_dir  = wr_en && (int'(bus_addr) == pio_pkg::WORD_DIR);
    assign wr_ien  = wr_en && (int'(bus_addr) == pio_pkg::WORD_IEN);
    assign wr_cap  = wr_en && (int'(bus_addr) == pio_pkg::WORD_CAP);
    assign wr_val  = bus_wdata[W-1:0];

    pio_in_stage #(.W(W), .TRIGGER(TRIGGER)) in_stage_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl),
        .evt    (evt)
    );

    // Output latch, direction and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_data) out_q  <= wr_val;
            if (wr_dir)  dir_q  <= wr_val;
            if (wr_ien)  mask_q <= wr_val;
        end
    end

    // Capture storage and interrupt forming, chosen by trigger kind.
    generate
        if (TRIGGER == pio_pkg::TRIG_LEVEL) begin : g_level_irq
            logic [W-1:0] unused_evt;
            logic         unused_wr_cap;
            assign unused_evt    = evt;
            assign unused_wr_cap = wr_cap;
            assign cap_q = '0;
            assign irq   = |(lvl & mask_q);
        end else begin : g_edge_irq
            logic [W-1:0] clr_vec;
            assign clr_vec = wr_cap ? wr_val : '0;
            pio_capture #(.W(W)) capture_i (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt),
                .clr   (clr_vec),
                .cap_q (cap_q)
            );
            assign irq = |(cap_q & mask_q);
        end
    endgenerate

    // Data view mixes driven values and sampled levels by direction.
    assign data_view = (dir_q & out_q) | (~dir_q & lvl);

    // Read multiplexer; unmapped words and bits above W read as zero.
    always_comb begin
        case (int'(bus_addr))
            pio_pkg::WORD_DATA: rd_mux = 32'(data_view);
            pio_pkg::WORD_DIR:  rd_mux = 32'(dir_q);
            pio_pkg::WORD_IEN:  rd_mux = 32'(mask_q);
            pio_pkg::WORD_CAP:  rd_mux = 32'(cap_q);
            default:            rd_mux = '0;
        endcase
    end

    // Read data register, loaded once per read request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;
endmodule

// File: rtl/pio_edge_port_chk.sv
// Module: property checker for pio_edge_port, attached through bind.
// Observes the ports plus the interrupt enable and capture registers.
module pio_edge_port_chk #(
    parameter int unsigned     PIN_COUNT = 32,
    parameter int unsigned     ADDR_W    = 3,
    parameter pio_pkg::trig_e TRIGGER   = pio_pkg::TRIG_RISE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic                 irq,
    input logic [PIN_COUNT-1:0] mask_q,
    input logic [PIN_COUNT-1:0] cap_q
);
    localparam logic [31:0] LIVE_BITS = 32'({PIN_COUNT{1'b1}});

    logic w_data, w_dir, w_cap, r_far;
    assign w_data = bus_sel && bus_wr && (int'(bus_addr) == pio_pkg::WORD_DATA);
    assign w_dir  = bus_sel && bus_wr && (int'(bus_addr) == pio_pkg::WORD_DIR);
    assign w_cap  = bus_sel && bus_wr && (int'(bus_addr) == pio_pkg::WORD_CAP);
    assign r_far  = bus_sel && !bus_wr && (int'(bus_addr) > pio_pkg::WORD_LAST);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && !irq && bus_rdata == '0));

    assert_oe_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !w_dir |=> $stable(pin_oe));

    assert_out_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !w_data |=> $stable(pin_out));

    assert_high_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LIVE_BITS) == '0);

    assert_far_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_far |=> bus_rdata == '0);

    // R6 and R8: a captured bit only drops after a write to the capture word.
    assert_capture_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !w_cap |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    // R10 and R11: no request without an enabled pin.
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));
endmodule

bind pio_edge_port pio_edge_port_chk #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .TRIGGER   (TRIGGER)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mask_q    (mask_q),
    .cap_q     (cap_q)
);

// File: tb/pio_edge_port_tb_top.sv
`timescale 1ns/1ps
// Directed bench: four instances (rising, falling, either-edge, level) share
// the bus and the pins. Writes reach all four; each read returns four results.
module pio_edge_port_tb_top;
    localparam int unsigned PINS = 12;
    localparam int unsigned AW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [PINS-1:0] pins = '0;

    logic [31:0]     rd_r, rd_f, rd_b, rd_l;
    logic [PINS-1:0] out_r, out_f, out_b, out_l;
    logic [PINS-1:0] oe_r, oe_f, oe_b, oe_l;
    logic            irq_r, irq_f, irq_b, irq_l;

    logic [31:0] v_r, v_f, v_b, v_l;
    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pio_edge_port #(.PIN_COUNT(PINS), .ADDR_W(AW), .TRIGGER(pio_pkg::TRIG_RISE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pins), .pin_out(out_r),
        .pin_oe(oe_r), .irq(irq_r));
    pio_edge_port #(.PIN_COUNT(PINS), .ADDR_W(AW), .TRIGGER(pio_pkg::TRIG_FALL)) dut_fall_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pins), .pin_out(out_f),
        .pin_oe(oe_f), .irq(irq_f));
    pio_edge_port #(.PIN_COUNT(PINS), .ADDR_W(AW), .TRIGGER(pio_pkg::TRIG_BOTH)) dut_both_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pins), .pin_out(out_b),
        .pin_oe(oe_b), .irq(irq_b));
    pio_edge_port #(.PIN_COUNT(PINS), .ADDR_W(AW), .TRIGGER(pio_pkg::TRIG_LEVEL)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pins), .pin_out(out_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        v_r = rd_r; v_f = rd_f; v_b = rd_b; v_l = rd_l;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [PINS-1:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic quiet_all();
        set_pins('0);
        settle();
        bus_write(2, 32'h0);
        bus_write(3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        eq("R1 pin_oe", 32'(oe_r), 32'h0);
        eq("R1 pin_out", 32'(out_r), 32'h0);
        eq("R1 irq", {28'h0, irq_r, irq_f, irq_b, irq_l}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            bus_read(a);
            eq("R1 register", v_r | v_f | v_b, 32'h0);
        end
    endtask

    task automatic t_drive();
        bus_write(0, 32'h0000_0A5A);
        bus_write(1, 32'h0000_00F0);
        eq("R2 pin_out", 32'(out_r), 32'h0A5A);
        eq("R2 pin_oe", 32'(oe_r), 32'h00F0);
        set_pins(12'h00F);
        settle();
        bus_read(0);
        eq("R3 data view", v_r, 32'h005F);
        eq("R2 pin_out held", 32'(out_r), 32'h0A5A);
        bus_write(1, 32'h0);
    endtask

    task automatic t_width();
        bus_write(1, 32'hFFFF_FFFF);
        bus_read(1);
        eq("R4 dir upper bits", v_r, 32'h0FFF);
        bus_write(2, 32'hFFFF_F000);
        bus_read(2);
        eq("R4 enable upper bits", v_r, 32'h0);
        bus_write(1, 32'h0);
    endtask

    task automatic t_far();
        bus_write(1, 32'h0000_0003);
        bus_write(5, 32'h0000_0FFF);
        bus_read(5);
        eq("R5 far read", v_r, 32'h0);
        bus_read(1);
        eq("R5 far write ignored", v_r, 32'h0003);
        bus_read(7);
        eq("R5 far read top", v_r, 32'h0);
        bus_write(1, 32'h0);
    endtask

    task automatic t_latency();
        bus_write(2, 32'h0000_0123);
        bus_read(2);
        eq("R12 read data after one edge", v_r, 32'h0123);
        repeat (3) @(negedge clk);
        eq("R12 read data held", rd_r, 32'h0123);
        bus_write(2, 32'h0);
    endtask

    task automatic t_edges();
        quiet_all();
        set_pins(12'h001);
        settle();
        bus_read(3);
        eq("R6 rise captured masked", v_r, 32'h001);
        eq("R7 fall ignores rise", v_f, 32'h000);
        eq("R7 either sees rise", v_b, 32'h001);
        set_pins(12'h000);
        settle();
        bus_read(3);
        eq("R6 rise sticky", v_r, 32'h001);
        eq("R7 fall captured", v_f, 32'h001);
        eq("R7 either sees fall", v_b, 32'h001);
        eq("R10 masked no irq", {29'h0, irq_r, irq_f, irq_b}, 32'h0);
    endtask

    task automatic t_clear();
        quiet_all();
        set_pins(12'h00C);
        settle();
        bus_write(3, 32'h0000_0004);
        bus_read(3);
        eq("R8 write one clears", v_r, 32'h008);
        bus_write(3, 32'h0);
        bus_read(3);
        eq("R8 write zero keeps", v_r, 32'h008);
    endtask

    task automatic t_collide();
        set_pins(12'h004);
        settle();
        @(negedge clk);
        pins = 12'h00C;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(3);
        eq("R9 set wins over clear", v_r, 32'h008);
    endtask

    task automatic t_irq_edge();
        quiet_all();
        set_pins(12'h010);
        settle();
        eq("R10 pending but masked", 32'(irq_r), 32'h0);
        bus_write(2, 32'h0000_0010);
        eq("R10 unmask pending", 32'(irq_r), 32'h1);
        bus_write(3, 32'h0000_0010);
        eq("R10 clear drops irq", 32'(irq_r), 32'h0);
        set_pins(12'h000);
        settle();
        @(negedge clk);
        pins = 12'h010;
        @(negedge clk);
        @(negedge clk);
        eq("R10 irq not before capture", 32'(irq_r), 32'h0);
        @(negedge clk);
        eq("R10 irq on third edge", 32'(irq_r), 32'h1);
        bus_write(2, 32'h0);
    endtask

    task automatic t_level();
        quiet_all();
        bus_write(2, 32'h0000_0020);
        eq("R11 idle low", 32'(irq_l), 32'h0);
        @(negedge clk);
        pins = 12'h020;
        @(negedge clk);
        eq("R11 low after one edge", 32'(irq_l), 32'h0);
        @(negedge clk);
        eq("R11 high after two edges", 32'(irq_l), 32'h1);
        bus_read(3);
        eq("R11 no capture", v_l, 32'h0);
        set_pins(12'h000);
        settle();
        eq("R11 follows pin low", 32'(irq_l), 32'h0);
        set_pins(12'h040);
        settle();
        eq("R11 masked pin ignored", 32'(irq_l), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_width();
        t_far();
        t_latency();
        t_edges();
        t_clear();
        t_collide();
        t_irq_edge();
        t_level();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule